// File: doc/BRIEF.md
# Bank Window Address Decoder

This block sits between a memory-mapped request path and a set of external memory banks. Each bank is described by one 32-bit control word that holds a base address, a power-of-two size code and an enable bit. For each incoming physical address, the decoder works out which enabled bank window contains it. It returns a one-hot hit vector, a binary bank index, the byte offset inside that bank, a miss flag and an overlap flag. These results are registered and appear one clock after the request.

A second, purely combinational path runs the other way. Given a requested base address and a byte size, it builds the control word that describes that bank. If the size is not one of the seven encodable values, it flags the request. The global enable models the controller-wide "memory configured" switch: while it is low, no address lands in any bank.

Top module: `bank_addr_decoder`

## Requirements
- R1: A bank's window starts at its control word masked with 0xFF800000, so bases fall on 8 MiB boundaries and the low 23 bits of the word never move the window.
- R2: Bits 19:17 of a control word hold a size code c, and the window spans 4 MiB shifted left by c bytes for c from 0 to 6; code 7 is illegal and that bank never hits.
- R3: Bit 0 of a control word enables the bank; a bank whose bit 0 is clear never hits.
- R4: While the global enable is low, every request reports a miss with an all-zero hit vector.
- R5: When several enabled windows contain the address, the lowest-numbered bank is selected and the overlap flag is set; the overlap flag is clear when at most one window matches.
- R6: The offset output equals the address minus the selected bank's base; on a miss the offset and the index are zero.
- R7: The miss flag is set exactly when no enabled, legally sized window contains the address.
- R8: Results are registered: they appear one clock after a cycle with the request-valid input high, the result-valid output follows request-valid by one clock, and all results hold while request-valid is low.
- R9: The hit vector has at most one bit set, and on a hit its set bit is the one at the reported index; bank 0 is bits 31:0 of the packed control input.
- R10: For a size of 4, 8, 16, 32, 64, 128 or 256 MiB, the built word is the requested base masked with 0xFF800000, ORed with the size code in bits 19:17, with bit 0 set, and the invalid flag is clear.
- R11: For any other requested size, the built word is zero and the invalid flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Controller-wide memory enable |
| bank_ctl | input | NUM_BANKS*32 | Packed bank control words, bank 0 in the low word |
| req_valid | input | 1 | Request address is valid this cycle |
| req_addr | input | 32 | Physical request address |
| rsp_valid | output | 1 | Registered results belong to a request |
| hit_vec | output | NUM_BANKS | One-hot selected bank |
| hit_idx | output | IDX_W | Binary index of the selected bank |
| hit_offset | output | 32 | Byte offset within the selected bank |
| miss | output | 1 | No bank contains the address |
| overlap | output | 1 | More than one window contains the address |
| bld_base | input | 32 | Requested base for word building |
| bld_size | input | 32 | Requested size in bytes for word building |
| bld_word | output | 32 | Built control word |
| bld_bad | output | 1 | Requested size cannot be encoded |

## Verification
The hardest cases to reach are a window whose end lies exactly at the 4 GiB wrap, where the limit does not fit in 32 bits, and overlapping windows in which a higher-numbered, larger bank also matches. The stimulus places a 256 MiB bank at 0xF0000000 and probes up to 0xFFFFFFFF. It also sets up a small bank inside a large one, next to a bank with the illegal size code and a disabled bank, and probes the first and last byte of every window and the bytes just outside them. Every 4 MiB step of the full address space is swept in each configuration.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  localparam int WORD_W        = 32;
  localparam int BASE_LSB      = 23;
  localparam int SIZE_LSB      = 17;
  localparam int SIZE_W        = 3;
  localparam int EN_BIT        = 0;
  localparam int MIN_SPAN_LOG2 = 22;
  localparam int NUM_CODES     = 7;
  localparam logic [SIZE_W-1:0] CODE_ILLEGAL = 3'd7;
  localparam logic [WORD_W-1:0] BASE_MASK =
    {{(WORD_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};

  function automatic logic [WORD_W:0] code_span(input logic [SIZE_W-1:0] code);
    code_span = (WORD_W+1)'(1) << (MIN_SPAN_LOG2 + int'(code));
  endfunction
endpackage

// File: rtl/bank_window.sv
module bank_window
  import bankdec_pkg::*;
(
  input  logic              glb_en,
  input  logic [WORD_W-1:0] ctl,
  input  logic [WORD_W-1:0] addr,
  output logic              hit,
  output logic [WORD_W-1:0] base
);
  logic [SIZE_W-1:0] code;
  logic [WORD_W:0]   limit;
  logic              usable;
  logic              above, below;

  always_comb begin
    code   = ctl[SIZE_LSB +: SIZE_W];
    base   = ctl & BASE_MASK;
    limit  = {1'b0, base} + code_span(code);
    usable = glb_en && ctl[EN_BIT] && (code != CODE_ILLEGAL);
    above  = {1'b0, addr} >= {1'b0, base};
    below  = {1'b0, addr} < limit;
    hit    = usable && above && below;
  end
endmodule

// File: rtl/bank_pick.sv
module bank_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     hits,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);
  localparam int CNT_W = $clog2(N + 1);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    idx    = '0;
    onehot = '0;
    cnt    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        idx    = IDX_W'(i);
        onehot = N'(1) << i;
      end
    end
    for (int i = 0; i < N; i++) cnt = cnt + CNT_W'(hits[i]);
    any   = (cnt != '0);
    multi = (cnt > CNT_W'(1));
  end
endmodule

// File: rtl/word_builder.sv
module word_builder
  import bankdec_pkg::*;
(
  input  logic [WORD_W-1:0] req_base,
  input  logic [WORD_W-1:0] req_size,
  output logic [WORD_W-1:0] word,
  output logic              bad
);
  logic [SIZE_W-1:0] code;
  logic              found;

  always_comb begin
    code  = '0;
    found = 1'b0;
    for (int c = 0; c < NUM_CODES; c++) begin
      if ({1'b0, req_size} == code_span(SIZE_W'(c))) begin
        code  = SIZE_W'(c);
        found = 1'b1;
      end
    end
    bad  = !found;
    word = '0;
    if (found) begin
      word = req_base & BASE_MASK;
      word[SIZE_LSB +: SIZE_W] = code;
      word[EN_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bankdec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        glb_en,
  input  logic [NUM_BANKS*WORD_W-1:0] bank_ctl,
  input  logic                        req_valid,
  input  logic [WORD_W-1:0]           req_addr,
  output logic                        rsp_valid,
  output logic [NUM_BANKS-1:0]        hit_vec,
  output logic [IDX_W-1:0]            hit_idx,
  output logic [WORD_W-1:0]           hit_offset,
  output logic                        miss,
  output logic                        overlap,
  input  logic [WORD_W-1:0]           bld_base,
  input  logic [WORD_W-1:0]           bld_size,
  output logic [WORD_W-1:0]           bld_word,
  output logic                        bld_bad
);
  logic [NUM_BANKS-1:0] raw_hit;
  logic [WORD_W-1:0]    bases [NUM_BANKS];
  logic [NUM_BANKS-1:0] sel_vec;
  logic [IDX_W-1:0]     sel_idx;
  logic                 sel_any, sel_multi;
  logic [WORD_W-1:0]    sel_base;

  logic [NUM_BANKS-1:0] nxt_vec;
  logic [IDX_W-1:0]     nxt_idx;
  logic [WORD_W-1:0]    nxt_off;
  logic                 nxt_miss, nxt_ovl;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
    bank_window u_win (
      .glb_en (glb_en),
      .ctl    (bank_ctl[b*WORD_W +: WORD_W]),
      .addr   (req_addr),
      .hit    (raw_hit[b]),
      .base   (bases[b])
    );
  end

  bank_pick #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_pick (
    .hits   (raw_hit),
    .onehot (sel_vec),
    .idx    (sel_idx),
    .any    (sel_any),
    .multi  (sel_multi)
  );

  word_builder u_bld (
    .req_base (bld_base),
    .req_size (bld_size),
    .word     (bld_word),
    .bad      (bld_bad)
  );

  always_comb begin
    sel_base = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (sel_vec[b]) sel_base = bases[b];
  end

  // next state, written with an explicit clock enable on req_valid
  always_comb begin
    nxt_vec  = hit_vec;
    nxt_idx  = hit_idx;
    nxt_off  = hit_offset;
    nxt_miss = miss;
    nxt_ovl  = overlap;
    if (req_valid) begin
      nxt_vec  = sel_vec;
      nxt_idx  = sel_any ? sel_idx : '0;
      nxt_off  = sel_any ? (req_addr - sel_base) : '0;
      nxt_miss = !sel_any;
      nxt_ovl  = sel_multi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      hit_vec    <= '0;
      hit_idx    <= '0;
      hit_offset <= '0;
      miss       <= 1'b0;
      overlap    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      hit_vec    <= nxt_vec;
      hit_idx    <= nxt_idx;
      hit_offset <= nxt_off;
      miss       <= nxt_miss;
      overlap    <= nxt_ovl;
    end
  end
endmodule

// File: rtl/bank_addr_decoder_chk.sv
module bank_addr_decoder_chk #(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 glb_en,
  input logic                 req_valid,
  input logic                 rsp_valid,
  input logic [NUM_BANKS-1:0] hit_vec,
  input logic [IDX_W-1:0]     hit_idx,
  input logic [31:0]          hit_offset,
  input logic                 miss,
  input logic                 overlap,
  input logic [31:0]          bld_word,
  input logic                 bld_bad
);
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(hit_vec) && $stable(hit_offset) && $stable(miss)));
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_idx_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !miss) |-> hit_vec[hit_idx]);
  assert_miss_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (hit_vec == '0 && hit_offset == '0));
  assert_global_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !glb_en) |=> miss);
  assert_overlap_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> !miss);
  assert_bad_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bld_bad |-> (bld_word == 32'd0));
  assert_good_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bld_bad |-> bld_word[0]);
endmodule

bind bank_addr_decoder bank_addr_decoder_chk #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .hit_vec(hit_vec), .hit_idx(hit_idx),
  .hit_offset(hit_offset), .miss(miss), .overlap(overlap),
  .bld_word(bld_word), .bld_bad(bld_bad)
);

// File: tb/tb_bank_addr_decoder.sv
`timescale 1ns/1ps
module tb_bank_addr_decoder;
  localparam int NB = 4;
  localparam int IW = 2;
  localparam longint MIB = 64'h100000;

  logic clk = 1'b0;
  logic rst_n, glb_en, req_valid;
  logic [NB*32-1:0] bank_ctl;
  logic [31:0] req_addr, bld_base, bld_size;
  logic rsp_valid, miss, overlap, bld_bad;
  logic [NB-1:0] hit_vec;
  logic [IW-1:0] hit_idx;
  logic [31:0] hit_offset, bld_word;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bank_addr_decoder #(.NUM_BANKS(NB)) dut (
    .clk, .rst_n, .glb_en, .bank_ctl, .req_valid, .req_addr,
    .rsp_valid, .hit_vec, .hit_idx, .hit_offset, .miss, .overlap,
    .bld_base, .bld_size, .bld_word, .bld_bad
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input logic [31:0] base, input int code, input bit en);
    return (base & 32'hFF800000) | (32'(code) << 17) | 32'(en);
  endfunction

  task automatic probe(input logic [31:0] a);
    logic [NB-1:0] ev;
    int eidx, cnt;
    longint eoff;
    ev = '0; eidx = 0; cnt = 0; eoff = 0;
    for (int b = NB - 1; b >= 0; b--) begin
      logic [31:0] w;
      longint base, span;
      int code;
      w = bank_ctl[b*32 +: 32];
      code = int'(w[19:17]);
      base = longint'(w & 32'hFF800000);
      span = (4 * MIB) << code;
      if (glb_en && w[0] && code != 7 && longint'(a) >= base && longint'(a) < base + span) begin
        cnt++; eidx = b; eoff = longint'(a) - base;
      end
    end
    if (cnt > 0) ev[eidx] = 1'b1;
    @(negedge clk); req_addr = a; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R8 rsp_valid", rsp_valid, 1);
    check(hit_vec == ev, "R9 R1 R2 R3 hit_vec", hit_vec, ev);
    check(miss == (cnt == 0), "R7 miss", miss, cnt == 0);
    check(overlap == (cnt > 1), "R5 overlap", overlap, cnt > 1);
    check(hit_idx == IW'(eidx), "R5 hit_idx", hit_idx, eidx);
    check(hit_offset == 32'(eoff), "R6 offset", hit_offset, eoff);
  endtask

  task automatic sweep();
    for (int i = 0; i < 1024; i++)
      probe(32'(i) * 32'h00400000 + ((32'(i) * 32'h1357) & 32'h003FFFFF));
    for (int b = 0; b < NB; b++) begin
      logic [31:0] w, base, span;
      w = bank_ctl[b*32 +: 32];
      base = w & 32'hFF800000;
      span = 32'(((4 * MIB) << w[19:17]) & 64'hFFFFFFFF);
      probe(base); probe(base - 1); probe(base + span - 1); probe(base + span);
    end
  endtask

  task automatic hold_test();
    logic [NB-1:0] v; logic [31:0] o;
    probe(32'h00000010);
    v = hit_vec; o = hit_offset;
    req_addr = 32'hFFFFFFF0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 idle rsp_valid", rsp_valid, 0);
    check(hit_vec == v && hit_offset == o, "R8 hold", hit_offset, o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; glb_en = 1'b0; req_valid = 1'b0; req_addr = '0;
    bank_ctl = '0; bld_base = '0; bld_size = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && hit_vec == 0 && miss == 0 && overlap == 0 && hit_offset == 0,
          "R8 reset state", {hit_vec, rsp_valid, miss, overlap}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // disjoint banks, low base bits set to show masking (R1)
    glb_en = 1'b1;
    bank_ctl = {mkword(32'h10000000, 6, 1), mkword(32'h08000000, 0, 1),
                mkword(32'h01000000, 3, 1), mkword(32'h00000000, 2, 1) | 32'h007C0000 & 32'h0} ;
    bank_ctl[31:0] = mkword(32'h00000000, 2, 1) | 32'h00700000 & 32'h0;
    bank_ctl[63:32] = mkword(32'h01000000, 3, 1) | 32'h00400006;
    sweep();
    hold_test();

    // global enable low (R4)
    glb_en = 1'b0;
    sweep();
    glb_en = 1'b1;

    // overlap, illegal code, disabled bank (R5 R2 R3)
    bank_ctl = {mkword(32'h00000000, 6, 0), mkword(32'h00000000, 7, 1),
                mkword(32'h00000000, 4, 1), mkword(32'h02000000, 1, 1)};
    sweep();

    // window ending at the top of the address space
    bank_ctl = {mkword(32'hF0000000, 6, 1), mkword(32'hE8000000, 5, 1),
                mkword(32'h40000000, 0, 1), mkword(32'h7F800000, 1, 1)};
    sweep();

    // word builder (R10 R11)
    for (int k = 18; k < 32; k++) begin
      for (int j = 0; j < 3; j++) begin
        logic [31:0] bs; bit legal; logic [31:0] ew;
        bs = (j == 0) ? 32'h12345678 : (j == 1) ? 32'hFFFFFFFF : 32'h00800000;
        legal = (k >= 22 && k <= 28);
        ew = legal ? mkword(bs, k - 22, 1) : 32'h0;
        bld_base = bs; bld_size = 32'(64'h1 << k);
        @(negedge clk);
        if (legal) check(bld_word == ew && !bld_bad, "R10 build", bld_word, ew);
        else       check(bld_word == 0 && bld_bad, "R11 build", bld_word, 0);
      end
    end
    foreach (bld_size[i]) ;
    bld_size = 32'h00C00000; @(negedge clk);
    check(bld_bad && bld_word == 0, "R11 12MiB", bld_word, 0);
    bld_size = 32'h0; @(negedge clk);
    check(bld_bad && bld_word == 0, "R11 zero", bld_word, 0);
    bld_size = 32'h00400001; @(negedge clk);
    check(bld_bad && bld_word == 0, "R11 odd", bld_word, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule